// File: doc/BRIEF.md
# Timer Compare Channel with PWM Output

This block is one channel of a general-purpose timer. A counter runs between zero and a programmable period, either upwards (wrapping to zero after the period) or downwards (reloading the period after zero). Alongside it, a compare unit watches the counter against a programmable threshold. It drives a single "prepare" level, which later output stages would shape into a pin signal. It also produces two one-cycle event flags: one when the counter steps onto the threshold and one when the counter wraps or reloads.

A 3-bit action code chooses what the prepare level does. The level can hold its value, set or clear on a threshold hit, or flip on every hit. It can be pinned low or high. It can also follow one of two complementary pulse-width waveforms. In these waveforms the period input sets the cycle length and the threshold sets the active width. A zero threshold gives a level that never becomes active, and a threshold above the period gives a level that never becomes inactive.

All outputs are registered and change together on the clock edge. The counter value is brought out so that the flags and the prepare level can be read against it in the same cycle.

Top module: `tcp_channel`

## Requirements
- R1: While `rst_n` is low, `count` is 0, `prep` is 0, and `match_flag` and `ovf_flag` are both 0.
- R2: With `en` high and `dir_down` low, `count` increases by one on each clock edge while it is below `period`. When `count` is at or above `period`, the next edge sets it to 0 and `ovf_flag` is 1 for that one cycle.
- R3: With `en` high and `dir_down` high, `count` decreases by one on each edge while it is nonzero. When `count` is 0, the next edge loads `period` into it and `ovf_flag` is 1 for that one cycle.
- R4: With `en` low, `count` keeps its value across the edge and neither flag is raised.
- R5: `match_flag` is 1 in exactly those cycles in which `count` has just taken a step (with `en` high) onto a value equal to `cmp`.
- R6: Action code 3'b000 (freeze) leaves `prep` unchanged.
- R7: Action code 3'b001 sets `prep` to 1 in a cycle where `match_flag` is 1. Code 3'b010 clears `prep` to 0 in such a cycle. In all other cycles, both codes leave `prep` unchanged.
- R8: Action code 3'b011 inverts `prep` in every cycle where `match_flag` is 1 and leaves it unchanged otherwise.
- R9: Action code 3'b100 drives `prep` to 0 and code 3'b101 drives it to 1, regardless of the counter, one edge after the code is applied.
- R10: Action code 3'b110 (PWM 0) with a nonzero `cmp` works as follows. When counting up, `prep` equals (`count` < `cmp`). When counting down, `prep` equals (`count` <= `cmp`). In both cases `prep` is evaluated against the `count` shown in the same cycle.
- R11: Action code 3'b111 (PWM 1) gives a `prep` that is the inverse of what code 3'b110 would give for the same `count`, `cmp` and direction.
- R12: Under code 3'b110, a `cmp` of 0 keeps `prep` at 0 and a `cmp` larger than `period` keeps `prep` at 1, whatever the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Counter advance enable |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| period | input | CNT_W | Period (auto-reload) value |
| cmp | input | CNT_W | Compare threshold |
| mode | input | 3 | Prepare-level action code |
| count | output | CNT_W | Current counter value |
| prep | output | 1 | Prepare level |
| match_flag | output | 1 | One-cycle compare hit pulse |
| ovf_flag | output | 1 | One-cycle wrap/reload pulse |

## Verification
The embedded properties check the following on every cycle: the counter holds whenever the enable is low, and the wrap flag lines up with a counter at zero (up) or at the period (down). They also check that the compare flag lines up with a counter equal to the threshold, that the freeze code leaves the level alone, and that the forcing codes pin it. Only the bench's sweep can show the full waveforms, because they depend on a counter history followed across many cycles. This covers the pulse-width shapes in both directions, the complement relation between the two waveform codes, saturation at a zero or oversized threshold, and the set, clear and toggle sequences.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

    typedef enum logic [2:0] {
        OM_FREEZE = 3'b000,
        OM_SET    = 3'b001,
        OM_CLEAR  = 3'b010,
        OM_TOGGLE = 3'b011,
        OM_LOW    = 3'b100,
        OM_HIGH   = 3'b101,
        OM_PWM0   = 3'b110,
        OM_PWM1   = 3'b111
    } out_mode_e;

endpackage

// File: rtl/tcp_counter.sv
module tcp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         dir_down,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt,
    output logic         ovf_q
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic wrap;

    // next-value logic: wrap on reaching the terminal value for the direction
    always_comb begin
        wrap    = 1'b0;
        cnt_nxt = cnt_q;
        if (en) begin
            if (dir_down) begin
                wrap    = (cnt_q == '0);
                cnt_nxt = wrap ? period : cnt_q - ONE;
            end else begin
                wrap    = (cnt_q >= period);
                cnt_nxt = wrap ? '0 : cnt_q + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            ovf_q <= wrap;
        end
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == $past(cnt_q)) && !ovf_q);

    assert_wrap_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q && $past(!dir_down) |-> cnt_q == '0);

    assert_reload_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q && $past(dir_down) |-> cnt_q == $past(period));

endmodule

// File: rtl/tcp_compare.sv
module tcp_compare #(
    parameter int W = 16
) (
    input  logic         en,
    input  logic         dir_down,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] cmp,
    output logic         hit,
    output logic         pwm0_lvl
);

    // a hit only counts when the counter actually steps onto the threshold
    always_comb begin
        hit = en && (cnt_nxt == cmp);
        if (cmp == '0)
            pwm0_lvl = 1'b0;
        else if (dir_down)
            pwm0_lvl = (cnt_nxt <= cmp);
        else
            pwm0_lvl = (cnt_nxt < cmp);
    end

endmodule

// File: rtl/tcp_outctl.sv
module tcp_outctl
    import tcp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       hit,
    input  logic       pwm0_lvl,
    output logic       prep_q,
    output logic       match_q
);

    out_mode_e act;
    logic      prep_nxt;

    assign act = out_mode_e'(mode);

    always_comb begin
        prep_nxt = prep_q;
        unique case (act)
            OM_FREEZE: prep_nxt = prep_q;
            OM_SET:    if (hit) prep_nxt = 1'b1;
            OM_CLEAR:  if (hit) prep_nxt = 1'b0;
            OM_TOGGLE: if (hit) prep_nxt = ~prep_q;
            OM_LOW:    prep_nxt = 1'b0;
            OM_HIGH:   prep_nxt = 1'b1;
            OM_PWM0:   prep_nxt = pwm0_lvl;
            OM_PWM1:   prep_nxt = ~pwm0_lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prep_q  <= 1'b0;
            match_q <= 1'b0;
        end else begin
            prep_q  <= prep_nxt;
            match_q <= hit;
        end
    end

    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'b000 |=> $stable(prep_q));

    assert_force_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'b100 |=> !prep_q);

    assert_force_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'b101 |=> prep_q);

endmodule

// File: rtl/tcp_channel.sv
module tcp_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dir_down,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp,
    input  logic [2:0]       mode,
    output logic [CNT_W-1:0] count,
    output logic             prep,
    output logic             match_flag,
    output logic             ovf_flag
);

    logic [CNT_W-1:0] cnt_nxt;
    logic             hit;
    logic             pwm0_lvl;

    tcp_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .dir_down(dir_down),
        .period  (period),
        .cnt_q   (count),
        .cnt_nxt (cnt_nxt),
        .ovf_q   (ovf_flag)
    );

    tcp_compare #(.W(CNT_W)) u_cmp (
        .en      (en),
        .dir_down(dir_down),
        .cnt_nxt (cnt_nxt),
        .cmp     (cmp),
        .hit     (hit),
        .pwm0_lvl(pwm0_lvl)
    );

    tcp_outctl u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .hit     (hit),
        .pwm0_lvl(pwm0_lvl),
        .prep_q  (prep),
        .match_q (match_flag)
    );

    assert_match_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_flag |-> count == $past(cmp));

endmodule

// File: tb/tb_tcp_channel.sv
module tb_tcp_channel;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         en;
    logic         dir_down;
    logic [W-1:0] period;
    logic [W-1:0] cmp;
    logic [2:0]   mode;
    logic [W-1:0] count;
    logic         prep;
    logic         match_flag;
    logic         ovf_flag;

    int n_tests = 0;
    int n_fail  = 0;

    int m_cnt;
    bit m_prep;
    bit m_ovf;
    bit m_match;

    always #4 clk = ~clk;

    tcp_channel #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .dir_down(dir_down),
        .period(period), .cmp(cmp), .mode(mode), .count(count),
        .prep(prep), .match_flag(match_flag), .ovf_flag(ovf_flag)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (mode %0d dir %0d per %0d cmp %0d)",
                     tag, what, act, exp, mode, dir_down, period, cmp);
        end
    endtask

    function automatic string prep_tag(int md, int c, int p);
        case (md)
            0: return "R6";
            1, 2: return "R7";
            3: return "R8";
            4, 5: return "R9";
            6: return (c == 0 || c > p) ? "R12" : "R10";
            default: return "R11";
        endcase
    endfunction

    // spec model of one clock edge, using inputs stable since the last negedge
    task automatic model_edge();
        int  nxt;
        bit  lvl;
        int  p = int'(period);
        int  c = int'(cmp);
        m_ovf = 1'b0;
        nxt   = m_cnt;
        if (en) begin
            if (dir_down) begin
                if (m_cnt == 0) begin nxt = p; m_ovf = 1'b1; end
                else nxt = m_cnt - 1;
            end else begin
                if (m_cnt >= p) begin nxt = 0; m_ovf = 1'b1; end
                else nxt = m_cnt + 1;
            end
        end
        m_match = en && (nxt == c);
        if (c == 0) lvl = 1'b0;
        else lvl = dir_down ? (nxt <= c) : (nxt < c);
        case (int'(mode))
            1: if (m_match) m_prep = 1'b1;
            2: if (m_match) m_prep = 1'b0;
            3: if (m_match) m_prep = ~m_prep;
            4: m_prep = 1'b0;
            5: m_prep = 1'b1;
            6: m_prep = lvl;
            7: m_prep = ~lvl;
            default: ;
        endcase
        m_cnt = nxt;
    endtask

    task automatic step();
        string ctag;
        ctag = !en ? "R4" : (dir_down ? "R3" : "R2");
        model_edge();
        @(negedge clk);
        chk(ctag, "count", int'(count), m_cnt);
        chk(ctag, "ovf_flag", int'(ovf_flag), int'(m_ovf));
        chk("R5", "match_flag", int'(match_flag), int'(m_match));
        chk(prep_tag(int'(mode), int'(cmp), int'(period)), "prep", int'(prep), int'(m_prep));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int per_list[5] = '{0, 1, 3, 7, 15};
        rst_n = 1'b0; en = 1'b1; dir_down = 1'b0;
        period = 4'd5; cmp = 4'd2; mode = 3'b101;
        repeat (3) @(negedge clk);
        // R1: reset state even with forcing-high mode and enable applied
        chk("R1", "count", int'(count), 0);
        chk("R1", "prep", int'(prep), 0);
        chk("R1", "match_flag", int'(match_flag), 0);
        chk("R1", "ovf_flag", int'(ovf_flag), 0);
        rst_n  = 1'b1;
        m_cnt  = 0;
        m_prep = 1'b0;

        for (int md = 0; md < 8; md++) begin
            for (int d = 0; d < 2; d++) begin
                for (int pi = 0; pi < 5; pi++) begin
                    int p = per_list[pi];
                    int cmax = (p + 1 > 15) ? 15 : p + 1;
                    for (int c = 0; c <= cmax; c++) begin
                        mode     = 3'(md);
                        dir_down = d[0];
                        period   = 4'(p);
                        cmp      = 4'(c);
                        for (int k = 0; k < 2 * (p + 1) + 3; k++) begin
                            en = !(k % 7 == 4);
                            step();
                        end
                    end
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule